// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host port that writes one 32-bit dword per cycle and a set of registers that are 64 or 128 bits wide. It stages the dwords of a wide target, tracks which of them have arrived, and when the target is complete it emits a single full-width commit. The commit carries the aligned base address, the assembled data and a size code. Writes to plain 32-bit registers bypass the staging logic and are committed at once.

Host addresses are split into 0x2000-byte pages below a memory window. Two 16-byte slots in every page, at page offsets 0x830 and 0xA10, hold write-only descriptor-pointer registers. Their high dword always triggers a commit. A partial write to one of them is discarded when the stage is busy with a different register. The timer-command dword on page 0 can optionally empty the stage, which reproduces a known interface quirk.

Top module: `wide_write_collector`

## Requirements
- R1: After reset no commit is issued, and the stage is empty. Writing three dwords of a 128-bit register after reset therefore produces no commit.
- R2: A 128-bit register is any 16-byte slot below 0x800000 that is neither a descriptor nor a plain register. Its dwords may arrive in any order. One cycle after the fourth distinct dword is written, commit_valid pulses for exactly one cycle. The pulse carries commit_size 2, the 16-byte-aligned address, and dword k (byte offset 4k) at bits 32k+31:32k.
- R3: Writing the same dword of a staged register again replaces its value and does not commit.
- R4: Addresses at or above 0x800000 are 64-bit words. Their two dwords are collected and committed with commit_size 1 and an 8-byte-aligned address. The low dword is at bits 31:0, the high dword at bits 63:32, and bits 127:64 are zero.
- R5: Page offsets 0x400 and 0x420 are plain registers. A write to one commits on the next cycle with commit_size 0, the dword-aligned address, and the data in bits 31:0 with zeros above. The stage is left as it was, except as stated in R10.
- R6: A dword written to a 64- or 128-bit register that differs from the one being staged restarts the stage with the new register. The earlier partial data is lost.
- R7: A write to dword 3 of a descriptor register always commits on the next cycle. If dwords 0 to 2 of the same register were staged, the full 128 bits are committed.
- R8: In every other case, the descriptor commit from R7 carries the written dword in bits 127:96 and zero in bits 95:0.
- R9: A write to dword 0, 1 or 2 of a descriptor register is dropped while the stage holds data for any other register. The staged data and the register it belongs to are kept.
- R10: With TIMER_QUIRK set, a write to offset 0x420 of page 0 empties the stage. The same offset on any other page does not.
- R11: Every commit of a 64- or 128-bit value, including a descriptor commit, empties the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host dword write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Dword written |
| commit_valid | output | 1 | One-cycle commit pulse |
| commit_addr | output | ADDR_W | Aligned target address |
| commit_data | output | 128 | Assembled commit data |
| commit_size | output | 2 | 0 dword, 1 64-bit, 2 128-bit |

## Verification
The assertions assume that wr_en is never unknown while out of reset. They also assume that wr_addr and wr_data are known whenever wr_en is high, and that the address bits above the page index fall in the configured address width. The stimulus drives only dword-aligned, fully known addresses, changes inputs at the falling edge, and holds wr_en low during reset. It mixes the orderings, interleavings and page numbers that the requirements name, and a behavioural model predicts every cycle's output.

// File: rtl/wwc_pkg.sv
package wwc_pkg;

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_QWORD  = 2'd1,
    CLS_DESC   = 2'd2,
    CLS_PLAIN  = 2'd3
  } wwc_class_e;

  typedef enum logic [1:0] {
    SZ_DWORD = 2'd0,
    SZ_QWORD = 2'd1,
    SZ_OWORD = 2'd2
  } wwc_size_e;

  localparam int DW = 32;
  localparam int LANES = 4;
  localparam int WIDE = DW * LANES;

  // one-hot lane select
  function automatic logic [LANES-1:0] lane_bit(input logic [1:0] idx);
    return LANES'(1) << idx;
  endfunction

  // lanes that make a target complete
  function automatic logic [LANES-1:0] full_lanes(input wwc_class_e cls);
    return (cls == CLS_QWORD) ? 4'b0011 : 4'b1111;
  endfunction

  // place one dword into a lane of the wide word
  function automatic logic [WIDE-1:0] put_lane(input logic [WIDE-1:0] cur,
                                               input logic [1:0] idx,
                                               input logic [DW-1:0] d);
    logic [WIDE-1:0] r;
    r = cur;
    for (int k = 0; k < LANES; k++) begin
      if (idx == k[1:0]) r[DW*k +: DW] = d;
    end
    return r;
  endfunction

endpackage

// File: rtl/wwc_classify.sv
module wwc_classify
  import wwc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_SHIFT = 13,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h80_0000,
  parameter logic [PAGE_SHIFT-1:0] OFF_DESC_A = 13'h830,
  parameter logic [PAGE_SHIFT-1:0] OFF_DESC_B = 13'hA10,
  parameter logic [PAGE_SHIFT-1:0] OFF_PLAIN = 13'h400,
  parameter logic [PAGE_SHIFT-1:0] OFF_TIMER = 13'h420
) (
  input  logic [ADDR_W-1:0] addr_i,
  output wwc_class_e        cls_o,
  output logic [1:0]        lane_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              timer_p0_o
);

  logic [PAGE_SHIFT-1:0] offset;
  logic in_mem, is_desc, is_plain, is_timer, page_zero;
  logic unused_lsb;

  assign unused_lsb = ^addr_i[1:0];
  assign offset     = addr_i[PAGE_SHIFT-1:0];
  assign in_mem     = (addr_i >= MEM_BASE);
  assign page_zero  = (addr_i[ADDR_W-1:PAGE_SHIFT] == '0);
  assign is_desc    = (offset[PAGE_SHIFT-1:4] == OFF_DESC_A[PAGE_SHIFT-1:4]) ||
                      (offset[PAGE_SHIFT-1:4] == OFF_DESC_B[PAGE_SHIFT-1:4]);
  assign is_timer   = (offset[PAGE_SHIFT-1:2] == OFF_TIMER[PAGE_SHIFT-1:2]);
  assign is_plain   = is_timer || (offset[PAGE_SHIFT-1:2] == OFF_PLAIN[PAGE_SHIFT-1:2]);

  always_comb begin
    if (in_mem)        cls_o = CLS_QWORD;
    else if (is_desc)  cls_o = CLS_DESC;
    else if (is_plain) cls_o = CLS_PLAIN;
    else               cls_o = CLS_NORMAL;
  end

  assign lane_o = in_mem ? {1'b0, addr_i[2]} : addr_i[3:2];

  always_comb begin
    unique case (cls_o)
      CLS_QWORD: base_o = {addr_i[ADDR_W-1:3], 3'b000};
      CLS_PLAIN: base_o = {addr_i[ADDR_W-1:2], 2'b00};
      default:   base_o = {addr_i[ADDR_W-1:4], 4'b0000};
    endcase
  end

  assign timer_p0_o = !in_mem && is_timer && page_zero;

endmodule

// File: rtl/wwc_stage.sv
module wwc_stage
  import wwc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter bit TIMER_QUIRK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  wwc_class_e        cls_i,
  input  logic [1:0]        lane_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              timer_p0_i,
  input  logic [DW-1:0]     data_i,
  output logic              fire_o,
  output logic [ADDR_W-1:0] fire_addr_o,
  output logic [WIDE-1:0]   fire_data_o,
  output logic [1:0]        fire_size_o
);

  logic [LANES-1:0]  mask_q, mask_d;
  logic [ADDR_W-1:0] base_q, base_d;
  wwc_class_e        cls_q, cls_d;
  logic [WIDE-1:0]   data_q, data_d;

  logic             same_tgt;
  logic [LANES-1:0] grown;
  logic [WIDE-1:0]  merged;

  // named events for the assertions
  logic ev_wide_commit, ev_drop, ev_restart, ev_quirk_clear;

  assign same_tgt = (mask_q != '0) && (base_q == base_i) && (cls_q == cls_i);
  assign grown    = (same_tgt ? mask_q : '0) | lane_bit(lane_i);
  assign merged   = put_lane(same_tgt ? data_q : '0, lane_i, data_i);

  always_comb begin
    mask_d         = mask_q;
    base_d         = base_q;
    cls_d          = cls_q;
    data_d         = data_q;
    fire_o         = 1'b0;
    fire_addr_o    = base_i;
    fire_data_o    = '0;
    fire_size_o    = SZ_OWORD;
    ev_wide_commit = 1'b0;
    ev_drop        = 1'b0;
    ev_restart     = 1'b0;
    ev_quirk_clear = 1'b0;
    if (wr_en_i) begin
      unique case (cls_i)
        CLS_PLAIN: begin
          fire_o      = 1'b1;
          fire_size_o = SZ_DWORD;
          fire_data_o = {{(WIDE-DW){1'b0}}, data_i};
          if (TIMER_QUIRK && timer_p0_i) begin
            mask_d         = '0;
            ev_quirk_clear = 1'b1;
          end
        end
        CLS_NORMAL, CLS_QWORD: begin
          ev_restart = (mask_q != '0) && !same_tgt;
          if (grown == full_lanes(cls_i)) begin
            fire_o         = 1'b1;
            ev_wide_commit = 1'b1;
            fire_size_o    = (cls_i == CLS_QWORD) ? SZ_QWORD : SZ_OWORD;
            fire_data_o    = (cls_i == CLS_QWORD) ?
                             {{(WIDE-2*DW){1'b0}}, merged[2*DW-1:0]} : merged;
            mask_d         = '0;
          end else begin
            mask_d = grown;
            base_d = base_i;
            cls_d  = cls_i;
            data_d = merged;
          end
        end
        default: begin
          if (lane_i == 2'd3) begin
            fire_o         = 1'b1;
            ev_wide_commit = 1'b1;
            fire_size_o    = SZ_OWORD;
            fire_data_o    = (grown == 4'b1111) ? merged :
                             {data_i, {(WIDE-DW){1'b0}}};
            mask_d         = '0;
          end else if ((mask_q != '0) && !same_tgt) begin
            ev_drop = 1'b1;
          end else begin
            mask_d = grown;
            base_d = base_i;
            cls_d  = cls_i;
            data_d = merged;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
      cls_q  <= CLS_NORMAL;
      data_q <= '0;
    end else begin
      mask_q <= mask_d;
      base_q <= base_d;
      cls_q  <= cls_d;
      data_q <= data_d;
    end
  end

  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> $stable(mask_q) && $stable(base_q) && $stable(data_q)); // R9
  AST_WIDE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wide_commit |=> (mask_q == '0)); // R11
  AST_QUIRK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_quirk_clear |=> (mask_q == '0)); // R10
  AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q != 4'b1111); // R2
  AST_QWORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q == CLS_QWORD) |-> (mask_q[3:2] == 2'b00)); // R4
  AST_RESTART_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restart && !ev_wide_commit |=> $countones(mask_q) == 1); // R6

endmodule

// File: rtl/wwc_commit_reg.sv
module wwc_commit_reg
  import wwc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDE-1:0]   data_i,
  input  logic [1:0]        size_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WIDE-1:0]   data_o,
  output logic [1:0]        size_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
      size_o  <= SZ_DWORD;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
        size_o <= size_i;
      end
    end
  end

  AST_DWORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && (size_o == SZ_DWORD) |-> (data_o[WIDE-1:DW] == '0)); // R5
  AST_QWORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && (size_o == SZ_QWORD) |-> (data_o[WIDE-1:2*DW] == '0) && (addr_o[2:0] == 3'b0)); // R4

endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import wwc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_SHIFT = 13,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h80_0000,
  parameter logic [PAGE_SHIFT-1:0] OFF_DESC_A = 13'h830,
  parameter logic [PAGE_SHIFT-1:0] OFF_DESC_B = 13'hA10,
  parameter logic [PAGE_SHIFT-1:0] OFF_PLAIN = 13'h400,
  parameter logic [PAGE_SHIFT-1:0] OFF_TIMER = 13'h420,
  parameter bit TIMER_QUIRK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [127:0]      commit_data,
  output logic [1:0]        commit_size
);

  wwc_class_e        cls;
  logic [1:0]        lane;
  logic [ADDR_W-1:0] base;
  logic              timer_p0;
  logic              fire;
  logic [ADDR_W-1:0] fire_addr;
  logic [WIDE-1:0]   fire_data;
  logic [1:0]        fire_size;

  wwc_classify #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .MEM_BASE(MEM_BASE),
    .OFF_DESC_A(OFF_DESC_A), .OFF_DESC_B(OFF_DESC_B),
    .OFF_PLAIN(OFF_PLAIN), .OFF_TIMER(OFF_TIMER)
  ) u_classify (
    .addr_i(wr_addr), .cls_o(cls), .lane_o(lane), .base_o(base),
    .timer_p0_o(timer_p0)
  );

  wwc_stage #(.ADDR_W(ADDR_W), .TIMER_QUIRK(TIMER_QUIRK)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .cls_i(cls), .lane_i(lane),
    .base_i(base), .timer_p0_i(timer_p0), .data_i(wr_data),
    .fire_o(fire), .fire_addr_o(fire_addr), .fire_data_o(fire_data),
    .fire_size_o(fire_size)
  );

  wwc_commit_reg #(.ADDR_W(ADDR_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .addr_i(fire_addr),
    .data_i(fire_data), .size_i(fire_size), .valid_o(commit_valid),
    .addr_o(commit_addr), .data_o(commit_data), .size_o(commit_size)
  );

  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(wr_en)); // R2
  AST_DESC_HIGH_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (cls == CLS_DESC) && (lane == 2'd3) |=> commit_valid && (commit_size == SZ_OWORD)); // R7
  AST_PLAIN_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (cls == CLS_PLAIN) |=> commit_valid && (commit_size == SZ_DWORD)); // R5
  AST_DESC_LOW_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (cls == CLS_DESC) && (lane != 2'd3) |=> !commit_valid); // R9

endmodule

// File: tb/wide_write_collector_bench.sv
module wide_write_collector_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [23:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         commit_valid;
  logic [23:0]  commit_addr;
  logic [127:0] commit_data;
  logic [1:0]   commit_size;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wide_write_collector u_wide_write_collector (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_size(commit_size)
  );

  // behavioural reference: kinds 0 wide, 1 memory word, 2 descriptor, 3 plain
  int unsigned m_mask = 0;
  int unsigned m_base = 0;
  int          m_kind = 0;
  logic [31:0] m_lane[4] = '{default: '0};

  function automatic int kind_of(int unsigned a);
    int unsigned off;
    if (a >= 32'h80_0000) return 1;
    off = a % 32'h2000;
    if ((off / 16) == 32'h83 || (off / 16) == 32'hA1) return 2;
    if ((off / 4) == 32'h100 || (off / 4) == 32'h108) return 3;
    return 0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit en, input int unsigned a, input logic [31:0] d,
                      input string tag);
    bit          e_v;
    int unsigned e_a;
    logic [127:0] e_d;
    int          e_s;
    int          k, ln;
    int unsigned b;
    bit          same;
    e_v = 0; e_a = 0; e_d = '0; e_s = 0;
    wr_en = en; wr_addr = a[23:0]; wr_data = d;
    if (en) begin
      k  = kind_of(a);
      ln = (k == 1) ? int'((a / 4) % 2) : int'((a / 4) % 4);
      b  = (k == 1) ? a - a % 8 : (k == 3) ? a - a % 4 : a - a % 16;
      same = (m_mask != 0) && (m_base == b) && (m_kind == k);
      if (k == 3) begin
        e_v = 1; e_a = b; e_s = 0; e_d = {96'b0, d};
        if (a == 32'h420) m_mask = 0;
      end else if (k == 2 && ln == 3) begin
        e_v = 1; e_a = b; e_s = 2;
        if (same && (m_mask | 8) == 15) e_d = {d, m_lane[2], m_lane[1], m_lane[0]};
        else e_d = {d, 96'b0};
        m_mask = 0;
      end else if (k == 2 && m_mask != 0 && !same) begin
        // dropped
      end else begin
        if (!same) begin m_mask = 0; m_lane = '{default: '0}; end
        m_lane[ln] = d;
        m_mask |= (1 << ln);
        m_base = b; m_kind = k;
        if ((k == 0 && m_mask == 15) || (k == 1 && m_mask == 3)) begin
          e_v = 1; e_a = b;
          e_s = (k == 1) ? 1 : 2;
          e_d = (k == 1) ? {64'b0, m_lane[1], m_lane[0]}
                         : {m_lane[3], m_lane[2], m_lane[1], m_lane[0]};
          m_mask = 0;
        end
      end
    end
    @(posedge clk);
    #1;
    wr_en = 0;
    check(tag, "valid", {127'b0, commit_valid}, {127'b0, e_v});
    if (e_v) begin
      check(tag, "addr", {104'b0, commit_addr}, {104'b0, e_a[23:0]});
      check(tag, "data", commit_data, e_d);
      check(tag, "size", {126'b0, commit_size}, {126'b0, e_s[1:0]});
    end
    @(negedge clk);
  endtask

  task automatic wr(input int unsigned a, input logic [31:0] d, input string tag);
    step(1, a, d, tag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle and partial after reset
    step(0, 0, 0, "R1");
    wr(32'h10, 32'hA0, "R1"); wr(32'h14, 32'hA1, "R1"); wr(32'h18, 32'hA2, "R1");
    // R2 completion in mixed order (also completes the above)
    wr(32'h1C, 32'hA3, "R2");
    wr(32'h2048, 32'hB2, "R2"); wr(32'h2040, 32'hB0, "R2");
    wr(32'h204C, 32'hB3, "R2"); wr(32'h2044, 32'hB1, "R2");
    step(0, 0, 0, "R2");
    // R3 overwrite
    wr(32'h100, 32'h1, "R3"); wr(32'h100, 32'h2, "R3");
    wr(32'h104, 32'h3, "R3"); wr(32'h108, 32'h4, "R3"); wr(32'h10C, 32'h5, "R3");
    // R6 restart and R11 empty
    wr(32'h200, 32'hC0, "R6"); wr(32'h204, 32'hC1, "R6");
    for (int i = 0; i < 4; i++) wr(32'h300 + 4 * i, 32'hD0 + i, "R6");
    wr(32'h208, 32'hC2, "R11"); wr(32'h20C, 32'hC3, "R11");
    wr(32'h200, 32'hC4, "R6"); wr(32'h204, 32'hC5, "R6");
    // R4 memory words
    wr(32'h80_000C, 32'hE1, "R4"); wr(32'h80_0008, 32'hE0, "R4");
    wr(32'h80_0010, 32'hE2, "R4"); wr(32'h80_0014, 32'hE3, "R4");
    // R5 plain dwords interleaved
    wr(32'h2400, 32'hF0, "R5");
    wr(32'h500, 32'h50, "R5"); wr(32'h400, 32'hF1, "R5");
    wr(32'h504, 32'h51, "R5"); wr(32'h508, 32'h52, "R5"); wr(32'h50C, 32'h53, "R5");
    // R7 full descriptor
    for (int i = 0; i < 4; i++) wr(32'h830 + 4 * i, 32'h70 + i, "R7");
    for (int i = 0; i < 4; i++) wr(32'h2A10 + 4 * i, 32'h78 + i, "R7");
    // R8 zero fill
    wr(32'h483C, 32'h80, "R8");
    wr(32'hA10, 32'h81, "R8"); wr(32'hA14, 32'h82, "R8"); wr(32'hA1C, 32'h83, "R8");
    wr(32'h800, 32'h84, "R8"); wr(32'h83C, 32'h85, "R8");
    wr(32'h804, 32'h86, "R11"); wr(32'h808, 32'h87, "R11"); wr(32'h80C, 32'h88, "R11");
    // R9 drops
    wr(32'h600, 32'h90, "R9"); wr(32'h834, 32'h91, "R9");
    wr(32'h604, 32'h92, "R9"); wr(32'h608, 32'h93, "R9"); wr(32'h60C, 32'h94, "R9");
    wr(32'hA10, 32'h95, "R9"); wr(32'h834, 32'h96, "R9"); wr(32'h2A14, 32'h97, "R9");
    wr(32'hA14, 32'h98, "R9"); wr(32'hA18, 32'h99, "R9"); wr(32'hA1C, 32'h9A, "R9");
    // R10 timer quirk
    wr(32'h700, 32'h10, "R10"); wr(32'h704, 32'h11, "R10"); wr(32'h420, 32'h12, "R10");
    wr(32'h708, 32'h13, "R10"); wr(32'h70C, 32'h14, "R10");
    wr(32'h700, 32'h15, "R10"); wr(32'h704, 32'h16, "R10");
    wr(32'h740, 32'h20, "R10"); wr(32'h744, 32'h21, "R10"); wr(32'h748, 32'h22, "R10");
    wr(32'h2420, 32'h23, "R10"); wr(32'h74C, 32'h24, "R10");
    step(0, 0, 0, "R10");
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule